// File: doc/BRIEF.md
# USB Suspend and Wakeup Event Controller

This block sits beside the packet engine of a full-speed USB device. It watches the decoded line state and turns bus conditions into sticky event flags. A bus reset is a long SE0. A suspend request is a long idle J. Any bus activity while suspended is an end-of-suspend event. Start-of-frame and packet-error strobes from the packet engine are also recorded. Software reads and clears the flags, enables them through a mask register and controls the block through a control register. That register holds a forced-suspend bit, a forced-reset bit, a power-down bit, a remote-wakeup (drive K) bit and two hardware-set cause bits.

The idle timer that raises the suspend request is armed by each detected bus reset. It is disarmed as long as software holds the forced-suspend bit. It re-arms only when a resume sequence ends, which is either the K state on the line returning to another state or the remote-wakeup bit being dropped. While suspend is forced, bus activity raises the end-of-suspend flag. A K state or an SE0 also records which of the two caused it. The end-of-suspend event has its own wakeup interrupt line. The other events share one interrupt line.

Top module: `usb_sus_irq_ctl`

## Requirements
- R1: After reset, status (address 0) and mask (address 1) read 00h, control (address 2) reads 06h, and `irq`, `wake_irq` and `drive_k` are 0.
- R2: An SE0 line state (`line_st`=2) held for RST_CYC consecutive cycles or more sets status bit 1 and pulses `usb_rst` once; a shorter SE0 does neither.
- R3: While armed, an idle J (`line_st`=0) held for more than SUSP_TICKS ticks of CLK_PER_TICK cycles sets status bit 3; any non-J cycle restarts the timing.
- R4: After a chip reset the idle timer is not armed: long idle sets no suspend flag until a bus reset has been detected.
- R5: While control bit 1 (forced suspend) is 1 the idle timer is disarmed, and after that bit is cleared it stays disarmed until a resume sequence ends (K state ending, or control bit 3 falling).
- R6: While control bit 1 is 1, any non-J line state sets status bit 2 (end of suspend); a K (`line_st`=1) sets control bit 7 and an SE0 sets control bit 6. With control bit 1 at 0 none of these are set.
- R7: `sof_stb` sets status bit 0; any bit of `err_stb` sets status bit 4.
- R8: A write to status clears each flag whose written bit is 0 and keeps each flag whose written bit is 1; a hardware event in the same cycle as a clearing write leaves its flag set. Control bits 7:6 follow the same rule on control writes.
- R9: `irq` is 1 exactly when some status bit among 4, 3, 1, 0 and the same mask bit are both 1 and `int_dis` is 0.
- R10: `wake_irq` is 1 exactly when status bit 2, mask bit 2 are 1 and `int_dis` is 0; status bit 2 never drives `irq`.
- R11: Control bit 3 drives `drive_k` while it is 1; control bits 5:4 and status and mask bits 7:5 always read 0.
- R12: Register address 3 reads 00h and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_st | input | 2 | Decoded line state: 0 J, 1 K, 2 SE0, 3 SE1 |
| sof_stb | input | 1 | Start-of-frame token received strobe |
| err_stb | input | N_ERR | Packet error strobes (one per error kind) |
| int_dis | input | 1 | Global interrupt disable |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Shared interrupt request |
| wake_irq | output | 1 | Dedicated end-of-suspend interrupt |
| drive_k | output | 1 | Request to drive K onto the bus (remote wakeup) |
| usb_rst | output | 1 | Bus reset to address and endpoint registers (detected or forced) |
| pdwn | output | 1 | Transceiver power-down (control bit 2) |
| susp_mode | output | 1 | Forced suspend in force (control bit 1) |

## Verification
On every cycle the assertions check the following. A detected reset gives a single pulse. A suspend event only follows an idle cycle and never follows two cycles of forced suspend. The end-of-suspend flag only rises under forced suspend. Flags are never cleared without a status write. `irq` is never raised while interrupts are disabled, and `wake_irq` only follows the end-of-suspend flag. The bench scenarios cover the rest. Those are the exact SE0 and idle length thresholds, the arming and disarming sequence around chip reset, forced suspend and resume end, the cause bits, and the write-zero-to-clear race. Random strobe, mask and clear traffic is compared against a bench model of the interrupt equations.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
   typedef enum logic [1:0] {
      LS_J   = 2'd0,
      LS_K   = 2'd1,
      LS_SE0 = 2'd2,
      LS_SE1 = 2'd3
   } line_e;

   localparam int ST_W     = 5;
   localparam int ST_SOF   = 0;
   localparam int ST_BRST  = 1;
   localparam int ST_ESUSP = 2;
   localparam int ST_SUSP  = 3;
   localparam int ST_ERR   = 4;

   localparam int CT_FRES   = 0;
   localparam int CT_FSUSP  = 1;
   localparam int CT_PDWN   = 2;
   localparam int CT_RESUME = 3;
   localparam int CT_RSTSEEN = 6;
   localparam int CT_RSMSEEN = 7;

   localparam logic [1:0] A_STAT = 2'd0;
   localparam logic [1:0] A_MASK = 2'd1;
   localparam logic [1:0] A_CTL  = 2'd2;

   localparam logic [7:0]      CTL_RESET  = 8'h06;
   localparam logic [ST_W-1:0] SHARED_SEL = 5'b11011;
endpackage

// File: rtl/usb_line_mon.sv
module usb_line_mon
   import usb_susp_pkg::*;
#(
   parameter int RST_CYC      = 120,
   parameter int CLK_PER_TICK = 48,
   parameter int SUSP_TICKS   = 3000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line,
   input  logic       fsusp,
   input  logic       fres,
   input  logic       drive_k,
   output logic       bus_rst,
   output logic       usb_rst,
   output logic       susp_evt
);
   localparam int RC_W = $clog2(RST_CYC + 1);
   localparam int TC_W = $clog2(SUSP_TICKS + 2);

   // ---------------- bus reset: long SE0 ----------------
   logic [RC_W-1:0] se0_cnt;
   logic            rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se0_cnt <= '0;
         rst_q   <= 1'b0;
      end else begin
         rst_q <= 1'b0;
         if (line == LS_SE0) begin
            if (se0_cnt != RC_W'(RST_CYC)) se0_cnt <= se0_cnt + 1'b1;
            if (se0_cnt == RC_W'(RST_CYC - 1)) rst_q <= 1'b1;
         end else begin
            se0_cnt <= '0;
         end
      end
   end

   assign bus_rst = rst_q;
   assign usb_rst = rst_q | fres;

   // ---------------- arming of the idle timer ----------------
   logic [1:0] line_q;
   logic       dk_q;
   logic       armed;
   logic       resume_end;

   assign resume_end = (line_q == LS_K && line != LS_K) || (dk_q && !drive_k);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= LS_J;
         dk_q   <= 1'b0;
         armed  <= 1'b0;
      end else begin
         line_q <= line;
         dk_q   <= drive_k;
         if (fsusp)                        armed <= 1'b0;
         else if (usb_rst || resume_end)   armed <= 1'b1;
      end
   end

   // ---------------- idle timer ----------------
   logic run;
   logic tick;
   assign run = armed && (line == LS_J);

   generate
      if (CLK_PER_TICK == 1) begin : g_tick_direct
         assign tick = run;
      end else begin : g_tick_div
         localparam int PC_W = $clog2(CLK_PER_TICK);
         logic [PC_W-1:0] pc;
         assign tick = run && (pc == PC_W'(CLK_PER_TICK - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pc <= '0;
            else if (!run || tick) pc <= '0;
            else            pc <= pc + 1'b1;
         end
      end
   endgenerate

   logic [TC_W-1:0] tcnt;
   logic            susp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt   <= '0;
         susp_q <= 1'b0;
      end else begin
         susp_q <= tick && (tcnt == TC_W'(SUSP_TICKS));
         if (!run)                                    tcnt <= '0;
         else if (tick && tcnt != TC_W'(SUSP_TICKS + 1)) tcnt <= tcnt + 1'b1;
      end
   end

   assign susp_evt = susp_q;

   assert_rst_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);

   assert_susp_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> ($past(line) == LS_J));

   assert_fsusp_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fsusp, 2) |-> !susp_q);
endmodule

// File: rtl/usb_evt_regs.sv
module usb_evt_regs
   import usb_susp_pkg::*;
#(
   parameter int N_ERR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       line,
   input  logic             sof_stb,
   input  logic [N_ERR-1:0] err_stb,
   input  logic             bus_rst,
   input  logic             susp_evt,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [7:0]       wdata,
   output logic [ST_W-1:0]  status,
   output logic [ST_W-1:0]  mask,
   output logic [7:0]       ctl,
   output logic [7:0]       rdata
);
   logic fsusp;
   assign fsusp = ctl[CT_FSUSP];

   logic [ST_W-1:0] set_vec;
   always_comb begin
      set_vec           = '0;
      set_vec[ST_SOF]   = sof_stb;
      set_vec[ST_BRST]  = bus_rst;
      set_vec[ST_ESUSP] = fsusp && (line != LS_J);
      set_vec[ST_SUSP]  = susp_evt;
      set_vec[ST_ERR]   = |err_stb;
   end

   logic [1:0] cause_set;
   assign cause_set = {fsusp && (line == LS_K), fsusp && (line == LS_SE0)};

   logic wr_st, wr_mk, wr_ct;
   assign wr_st = wr && (addr == A_STAT);
   assign wr_mk = wr && (addr == A_MASK);
   assign wr_ct = wr && (addr == A_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
         ctl    <= CTL_RESET;
      end else begin
         status <= (status & (wr_st ? wdata[ST_W-1:0] : {ST_W{1'b1}})) | set_vec;
         if (wr_mk) mask <= wdata[ST_W-1:0];
         ctl[7:6] <= (ctl[7:6] & (wr_ct ? wdata[7:6] : 2'b11)) | cause_set;
         ctl[5:4] <= 2'b00;
         if (wr_ct) ctl[3:0] <= wdata[3:0];
      end
   end

   always_comb begin
      unique case (addr)
         A_STAT:  rdata = {{(8-ST_W){1'b0}}, status};
         A_MASK:  rdata = {{(8-ST_W){1'b0}}, mask};
         A_CTL:   rdata = ctl;
         default: rdata = 8'h00;
      endcase
   end

   assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_st |=> ((status & $past(status)) == $past(status)));

   assert_esusp_under_fsusp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_ESUSP]) |-> $past(fsusp));
endmodule

// File: rtl/usb_sus_irq_ctl.sv
module usb_sus_irq_ctl
   import usb_susp_pkg::*;
#(
   parameter int RST_CYC        = 120,
   parameter int CLK_PER_TICK   = 48,
   parameter int SUSP_TICKS     = 3000,
   parameter int N_ERR          = 4,
   parameter bit WAKE_USES_MASK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       line_st,
   input  logic             sof_stb,
   input  logic [N_ERR-1:0] err_stb,
   input  logic             int_dis,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             irq,
   output logic             wake_irq,
   output logic             drive_k,
   output logic             usb_rst,
   output logic             pdwn,
   output logic             susp_mode
);
   generate
      if (RST_CYC < 1)      begin : g_bad_rst   $error("RST_CYC must be at least 1"); end
      if (CLK_PER_TICK < 1) begin : g_bad_tick  $error("CLK_PER_TICK must be at least 1"); end
      if (SUSP_TICKS < 1)   begin : g_bad_susp  $error("SUSP_TICKS must be at least 1"); end
      if (N_ERR < 1)        begin : g_bad_err   $error("N_ERR must be at least 1"); end
   endgenerate

   logic [ST_W-1:0] status, mask;
   logic [7:0]      ctl;
   logic            bus_rst, susp_evt;

   usb_line_mon #(
      .RST_CYC(RST_CYC), .CLK_PER_TICK(CLK_PER_TICK), .SUSP_TICKS(SUSP_TICKS)
   ) u_mon (
      .clk(clk), .rst_n(rst_n), .line(line_st),
      .fsusp(ctl[CT_FSUSP]), .fres(ctl[CT_FRES]), .drive_k(ctl[CT_RESUME]),
      .bus_rst(bus_rst), .usb_rst(usb_rst), .susp_evt(susp_evt)
   );

   usb_evt_regs #(.N_ERR(N_ERR)) u_regs (
      .clk(clk), .rst_n(rst_n), .line(line_st),
      .sof_stb(sof_stb), .err_stb(err_stb), .bus_rst(bus_rst), .susp_evt(susp_evt),
      .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .status(status), .mask(mask), .ctl(ctl), .rdata(reg_rdata)
   );

   assign irq       = (|(status & mask & SHARED_SEL)) && !int_dis;
   assign drive_k   = ctl[CT_RESUME];
   assign pdwn      = ctl[CT_PDWN];
   assign susp_mode = ctl[CT_FSUSP];

   generate
      if (WAKE_USES_MASK) begin : g_wake_masked
         assign wake_irq = status[ST_ESUSP] && mask[ST_ESUSP] && !int_dis;
      end else begin : g_wake_free
         assign wake_irq = status[ST_ESUSP] && !int_dis;
      end
   endgenerate

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !int_dis);

   assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> status[ST_ESUSP]);
endmodule

// File: tb/tb_usb_sus_irq_ctl.sv
module tb_usb_sus_irq_ctl;
   localparam int RC = 4, PT = 2, ST = 20, NE = 3;
   localparam int SUSP_AT = (ST + 1) * PT;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] line_st = 2'd0;
   logic sof_stb = 1'b0, int_dis = 1'b0, reg_wr = 1'b0;
   logic [NE-1:0] err_stb = '0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00, reg_rdata;
   logic irq, wake_irq, drive_k, usb_rst, pdwn, susp_mode;

   int n_chk = 0, n_fail = 0, rst_pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   usb_sus_irq_ctl #(.RST_CYC(RC), .CLK_PER_TICK(PT), .SUSP_TICKS(ST), .N_ERR(NE),
                     .WAKE_USES_MASK(1'b1)) dut (.*);

   always @(posedge clk) if (rst_n && usb_rst) rst_pulses++;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
   endtask

   task automatic hold(input logic [1:0] ls, input int n);
      line_st = ls;
      repeat (n) @(negedge clk);
   endtask

   function automatic logic exp_irq(input logic [4:0] s, input logic [4:0] m, input logic d);
      return (|(s & m & 5'b11011)) && !d;
   endfunction

   logic [7:0] d;
   logic [4:0] st_m, mk_m;

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd(2'd0, d); check("R1 status", d, 8'h00);
      rd(2'd1, d); check("R1 mask", d, 8'h00);
      rd(2'd2, d); check("R1 control", d, 8'h06);
      check("R1 outputs", {5'd0, irq, wake_irq, drive_k}, 8'h00);
      // R12 address 3
      wr(2'd3, 8'hFF);
      rd(2'd3, d); check("R12 addr3", d, 8'h00);
      rd(2'd2, d); check("R12 ctl unchanged", d, 8'h06);

      // R4: unarmed after chip reset
      wr(2'd2, 8'h00);
      hold(2'd0, 3 * SUSP_AT);
      rd(2'd0, d); check("R4 no suspend before bus reset", d, 8'h00);

      // R2: short SE0
      hold(2'd2, RC - 1); hold(2'd0, 4);
      rd(2'd0, d); check("R2 short SE0 no flag", d, 8'h00);
      check("R2 short SE0 no pulse", 8'(rst_pulses), 8'd0);
      // R2: long SE0
      hold(2'd2, RC + 4);
      // R3: idle with restart
      hold(2'd0, SUSP_AT - 12); hold(2'd1, 1);
      hold(2'd0, SUSP_AT - 6);
      rd(2'd0, d); check("R2 long SE0 flag", d, 8'h02);
      check("R2 one pulse", 8'(rst_pulses), 8'd1);
      check("R3 restart after K", {7'd0, d[3]}, 8'd0);
      check("R6 no esusp without forced suspend", {7'd0, d[2]}, 8'd0);
      hold(2'd0, 14);
      rd(2'd0, d); check("R3 suspend after idle", d, 8'h0A);

      // R8 clear, keep and race
      wr(2'd0, 8'h00);
      rd(2'd0, d); check("R8 clear all", d, 8'h00);
      @(negedge clk); sof_stb = 1'b1; err_stb = 3'b010;
      @(negedge clk); sof_stb = 1'b0; err_stb = '0;
      rd(2'd0, d); check("R7 sof and err", d, 8'h11);
      wr(2'd0, 8'h10);
      rd(2'd0, d); check("R8 write1 keeps write0 clears", d, 8'h10);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; sof_stb = 1'b1;
      @(negedge clk); reg_wr = 1'b0; sof_stb = 1'b0;
      rd(2'd0, d); check("R8 hardware set wins race", d, 8'h01);
      wr(2'd0, 8'h00);

      // R5/R6 forced suspend
      wr(2'd2, 8'h02);
      hold(2'd0, 3 * SUSP_AT);
      rd(2'd0, d); check("R5 no suspend while forced", d, 8'h00);
      hold(2'd1, 3); hold(2'd0, 1);
      rd(2'd0, d); check("R6 esusp on K", d, 8'h04);
      rd(2'd2, d); check("R6 resume cause", d, 8'h82);
      check("R10 wake masked off", {7'd0, wake_irq}, 8'd0);
      wr(2'd1, 8'h04);
      check("R10 wake on", {6'd0, wake_irq, irq}, 8'h02);
      int_dis = 1'b1; #1;
      check("R10 wake gated by int_dis", {7'd0, wake_irq}, 8'd0);
      int_dis = 1'b0;
      hold(2'd2, 2); hold(2'd0, 1);
      rd(2'd2, d); check("R6 reset cause", d, 8'hC2);
      wr(2'd2, 8'h00);
      rd(2'd2, d); check("R8 cause bits cleared", d, 8'h00);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      hold(2'd0, 3 * SUSP_AT);
      rd(2'd0, d); check("R5 disarmed until resume ends", d, 8'h00);
      hold(2'd1, 2);
      hold(2'd0, SUSP_AT + 8);
      rd(2'd0, d); check("R5 rearmed after resume end", d, 8'h08);
      rd(2'd2, d); check("R6 no cause without forced suspend", d, 8'h00);

      // R11 drive K and reserved bits
      wr(2'd2, 8'h38);
      rd(2'd2, d); check("R11 reserved read zero", d, 8'h08);
      check("R11 drive_k on", {7'd0, drive_k}, 8'd1);
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check("R11 mask upper zero", d, 8'h1F);
      wr(2'd2, 8'h00);
      check("R11 drive_k off", {7'd0, drive_k}, 8'd0);

      // random phase (R7 R8 R9), forced suspend keeps timer off
      wr(2'd2, 8'h02);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      st_m = '0; mk_m = '0; int_dis = 1'b0;
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [7:0] r;
         op = int'($urandom % 5);
         r  = 8'($urandom);
         case (op)
            0: begin
               @(negedge clk); sof_stb = 1'b1;
               @(negedge clk); sof_stb = 1'b0; st_m[0] = 1'b1;
            end
            1: begin
               @(negedge clk); err_stb = (r[2:0] == 3'd0) ? 3'd4 : r[2:0];
               @(negedge clk); err_stb = '0; st_m[4] = 1'b1;
            end
            2: begin wr(2'd0, r); st_m = st_m & r[4:0]; end
            3: begin wr(2'd1, r); mk_m = r[4:0]; end
            default: begin @(negedge clk); int_dis = r[0]; end
         endcase
         rd(2'd0, d); check("R8 random status", d, {3'd0, st_m});
         check("R9 random irq", {7'd0, irq}, {7'd0, exp_irq(st_m, mk_m, int_dis)});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule